// File: doc/BRIEF.md
# IN Endpoint Response and Data Toggle Controller

This block decides how a single USB IN endpoint replies when the host polls it with an IN token. For each token it produces one response: a STALL handshake, a NAK handshake, a data packet, or a zero-length data packet. For data packets it also chooses the PID, DATA0 or DATA1. It keeps the endpoint's data-toggle state and advances that state according to the operating mode. In normal bulk or interrupt mode the toggle moves only when the host ACKs. In rate-feedback mode it moves on every transmitted packet. Packet storage, CRC generation and line encoding live in neighbouring blocks.

Three control levels set the behaviour, and all of them are held by a software-visible register elsewhere. The first is a stall request. The second is a combined isochronous/toggle-reinit bit. While this bit is high, every data packet carries DATA0. When it is raised for one packet and then dropped, the toggle sequence restarts, and the next packet goes out as DATA1. The third is a rate-feedback mode bit. Three single-cycle strobes report bus events: a token arrival, the end of a data transmission, and a received host ACK. A level reports whether a packet is ready.

Top module: `usb_in_ep_resp`

## Requirements
- R1: A response appears with `resp_vld_o` high for exactly the cycle after the cycle in which `in_token_i` was sampled high; with no token, `resp_vld_o` stays low.
- R2: With `stall_i` high at the token, the response code is STALL (`resp_o` = 1) and `pid_o` = 0, whatever the other inputs are.
- R3: With `stall_i` low, `iso_init_i` high and `pkt_ready_i` high, the response is DATA (`resp_o` = 2) with `pid_o` = 0 (DATA0).
- R4: With `stall_i` low, `iso_init_i` high and `pkt_ready_i` low, the response is a zero-length packet (`resp_o` = 3) with `pid_o` = 0.
- R5: With `stall_i`, `iso_init_i` and `pkt_ready_i` all low, the response is NAK (`resp_o` = 0) with `pid_o` = 0.
- R6: With `stall_i` and `iso_init_i` low and `pkt_ready_i` high, the response is DATA (`resp_o` = 2). Its `pid_o` equals `toggle_o` at the token, where 0 = DATA0 and 1 = DATA1.
- R7: In normal mode (`iso_init_i` = 0, `rate_fb_i` = 0), `host_ack_i` inverts `toggle_o` in the next cycle. `tx_done_i` without an ACK leaves `toggle_o` unchanged.
- R8: In rate-feedback mode (`iso_init_i` = 0, `rate_fb_i` = 1), `tx_done_i` inverts `toggle_o` in the next cycle, and `host_ack_i` has no effect on it.
- R9: A rising `iso_init_i` clears `toggle_o` to 0 in the next cycle. While `iso_init_i` is high, `tx_done_i` sets `toggle_o` to 1. As a result, the first data packet after `iso_init_i` falls again carries DATA1.
- R10: After reset, `toggle_o`, `resp_vld_o`, `resp_o` and `pid_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Stall request level |
| iso_init_i | input | 1 | Isochronous / toggle re-initialise level |
| rate_fb_i | input | 1 | Rate-feedback mode level |
| in_token_i | input | 1 | IN token received strobe |
| pkt_ready_i | input | 1 | A packet is ready to send |
| tx_done_i | input | 1 | Data packet transmission finished strobe |
| host_ack_i | input | 1 | Host ACK received strobe |
| resp_vld_o | output | 1 | Response valid strobe |
| resp_o | output | 2 | Response code: 0 NAK, 1 STALL, 2 DATA, 3 zero-length DATA |
| pid_o | output | 1 | Data PID: 0 DATA0, 1 DATA1 |
| toggle_o | output | 1 | Current data-toggle state |

## Verification
The assertions take several things for granted about the inputs. Each strobe lasts a single cycle. A host ACK only ever follows a transmitted data packet. The control levels do not change in the same cycle as a token or strobe that they govern. The bench honours all of this by changing inputs only on the falling clock edge. It raises at most one event strobe per stimulus step and sets the control levels one step before the token or strobe that depends on them. The sequence of toggle tests is ordered so that the toggle state always sits at a known value before each response check.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;
  localparam int unsigned RESP_W = 2;

  typedef enum logic [RESP_W-1:0] {
    RSP_NAK   = 2'd0,
    RSP_STALL = 2'd1,
    RSP_DATA  = 2'd2,
    RSP_ZLP   = 2'd3
  } resp_e;

  localparam logic PID_DATA0 = 1'b0;
  localparam logic PID_DATA1 = 1'b1;
endpackage

// File: rtl/usb_in_toggle_ctl.sv
module usb_in_toggle_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic iso_init_i,
  input  logic rate_fb_i,
  input  logic tx_done_i,
  input  logic host_ack_i,
  output logic toggle_o
);
  import usb_in_ep_pkg::*;

  logic toggle_q, toggle_d;
  logic iso_q;
  logic iso_rise;
  logic adv;

  assign iso_rise = iso_init_i & ~iso_q;
  // advance event depends on mode
  assign adv = rate_fb_i ? tx_done_i : host_ack_i;

  always_comb begin
    toggle_d = toggle_q;
    if (iso_init_i) begin
      if (tx_done_i)     toggle_d = PID_DATA1;
      else if (iso_rise) toggle_d = PID_DATA0;
    end else if (adv) begin
      toggle_d = ~toggle_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      toggle_q <= PID_DATA0;
      iso_q    <= 1'b0;
    end else begin
      toggle_q <= toggle_d;
      iso_q    <= iso_init_i;
    end
  end

  assign toggle_o = toggle_q;

  AST_NORMAL_ACK_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!iso_init_i && !rate_fb_i && host_ack_i) |=> (toggle_q != $past(toggle_q))); // R7
  AST_NORMAL_NOACK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!iso_init_i && !rate_fb_i && !host_ack_i) |=> $stable(toggle_q)); // R7
  AST_RATEFB_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!iso_init_i && rate_fb_i && tx_done_i) |=> (toggle_q != $past(toggle_q))); // R8
  AST_RATEFB_ACK_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!iso_init_i && rate_fb_i && !tx_done_i) |=> $stable(toggle_q)); // R8
  AST_ISO_REINIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iso_init_i && !iso_q && !tx_done_i) |=> (toggle_q == PID_DATA0)); // R9
  AST_ISO_SENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iso_init_i && tx_done_i) |=> (toggle_q == PID_DATA1)); // R9
endmodule

// File: rtl/usb_in_resp_sel.sv
module usb_in_resp_sel
  import usb_in_ep_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic              iso_init_i,
  input  logic              in_token_i,
  input  logic              pkt_ready_i,
  input  logic              toggle_i,
  output logic              resp_vld_o,
  output logic [RESP_W-1:0] resp_o,
  output logic              pid_o
);
  resp_e resp_d, resp_q;
  logic  pid_d, pid_q, vld_q;

  // stall > data > iso zero-length > nak
  always_comb begin
    resp_d = RSP_NAK;
    pid_d  = PID_DATA0;
    if (stall_i) begin
      resp_d = RSP_STALL;
    end else if (pkt_ready_i) begin
      resp_d = RSP_DATA;
      pid_d  = iso_init_i ? PID_DATA0 : toggle_i;
    end else if (iso_init_i) begin
      resp_d = RSP_ZLP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      resp_q <= RSP_NAK;
      pid_q  <= PID_DATA0;
    end else begin
      vld_q <= in_token_i;
      if (in_token_i) begin
        resp_q <= resp_d;
        pid_q  <= pid_d;
      end
    end
  end

  assign resp_vld_o = vld_q;
  assign resp_o     = resp_q;
  assign pid_o      = pid_q;

  AST_ONE_RESP_PER_TOKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_token_i |=> resp_vld_o); // R1
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_token_i |=> !resp_vld_o); // R1
  AST_STALL_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_token_i && stall_i) |=> (resp_o == RSP_STALL && pid_o == PID_DATA0)); // R2
  AST_ISO_DATA0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_token_i && iso_init_i) |=> (pid_o == PID_DATA0)); // R3
  AST_NAK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_token_i && !stall_i && !iso_init_i && !pkt_ready_i) |=> (resp_o == RSP_NAK)); // R5
endmodule

// File: rtl/usb_in_ep_resp.sv
module usb_in_ep_resp (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stall_i,
  input  logic       iso_init_i,
  input  logic       rate_fb_i,
  input  logic       in_token_i,
  input  logic       pkt_ready_i,
  input  logic       tx_done_i,
  input  logic       host_ack_i,
  output logic       resp_vld_o,
  output logic [1:0] resp_o,
  output logic       pid_o,
  output logic       toggle_o
);
  import usb_in_ep_pkg::*;

  logic toggle;

  usb_in_toggle_ctl i_toggle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .iso_init_i (iso_init_i),
    .rate_fb_i  (rate_fb_i),
    .tx_done_i  (tx_done_i),
    .host_ack_i (host_ack_i),
    .toggle_o   (toggle)
  );

  usb_in_resp_sel i_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stall_i     (stall_i),
    .iso_init_i  (iso_init_i),
    .in_token_i  (in_token_i),
    .pkt_ready_i (pkt_ready_i),
    .toggle_i    (toggle),
    .resp_vld_o  (resp_vld_o),
    .resp_o      (resp_o),
    .pid_o       (pid_o)
  );

  assign toggle_o = toggle;

  AST_DATA_PID_TRACKS_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_token_i && !stall_i && !iso_init_i && pkt_ready_i) |=>
      (resp_o == RSP_DATA && pid_o == $past(toggle_o))); // R6
endmodule

// File: tb/test_usb_in_ep_resp.sv
module test_usb_in_ep_resp;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stall = 0, iso = 0, rfb = 0, tok = 0, rdy = 0, done = 0, ack = 0;
  logic       resp_vld;
  logic [1:0] resp;
  logic       pid, toggle;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  usb_in_ep_resp i_usb_in_ep_resp (
    .clk_i(clk), .rst_ni(rst_n), .stall_i(stall), .iso_init_i(iso), .rate_fb_i(rfb),
    .in_token_i(tok), .pkt_ready_i(rdy), .tx_done_i(done), .host_ack_i(ack),
    .resp_vld_o(resp_vld), .resp_o(resp), .pid_o(pid), .toggle_o(toggle)
  );

  // {stall, iso, rdy, resp[1:0], pid}
  localparam logic [5:0] VEC [8] = '{
    6'b000_00_0, 6'b001_10_0, 6'b010_11_0, 6'b011_10_0,
    6'b100_01_0, 6'b101_01_0, 6'b110_01_0, 6'b111_01_0
  };

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic token(input logic rd, string req, int exp_resp, int exp_pid);
    @(negedge clk);
    rdy = rd; tok = 1'b1;
    @(negedge clk);
    tok = 1'b0;
    check({req, " vld"}, int'(resp_vld), 1);
    check({req, " resp"}, int'(resp), exp_resp);
    check({req, " pid"}, int'(pid), exp_pid);
  endtask

  task automatic strobe(input logic d, input logic a, string req, int exp_tog);
    @(negedge clk);
    done = d; ack = a;
    @(negedge clk);
    done = 1'b0; ack = 1'b0;
    check(req, int'(toggle), exp_tog);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 toggle", int'(toggle), 0);
    check("R10 vld", int'(resp_vld), 0);
    check("R10 resp", int'(resp), 0);
    check("R10 pid", int'(pid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 idle no resp", int'(resp_vld), 0);

    // table walk, toggle at DATA0
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      stall = VEC[i][5]; iso = VEC[i][4];
      token(VEC[i][3], $sformatf("R2/R3/R4/R5 vec%0d", i), int'(VEC[i][2:1]), int'(VEC[i][0]));
      @(negedge clk);
      check("R1 single-cycle resp", int'(resp_vld), 0);
    end
    @(negedge clk);
    stall = 0; iso = 0; rfb = 0;
    @(negedge clk);
    check("R9 iso toggle at 0", int'(toggle), 0);

    // normal mode
    strobe(1'b1, 1'b0, "R7 tx_done no ack hold", 0);
    strobe(1'b0, 1'b1, "R7 ack flips", 1);
    token(1'b1, "R6 data pid1", 2, 1);
    strobe(1'b1, 1'b0, "R7 tx_done no ack hold 1", 1);
    strobe(1'b0, 1'b1, "R7 ack flips back", 0);
    token(1'b1, "R6 data pid0", 2, 0);

    // rate feedback
    @(negedge clk); rfb = 1;
    strobe(1'b0, 1'b1, "R8 ack ignored", 0);
    strobe(1'b1, 1'b0, "R8 tx flips", 1);
    strobe(1'b1, 1'b0, "R8 tx flips again", 0);
    strobe(1'b1, 1'b0, "R8 tx flips third", 1);
    @(negedge clk); rfb = 0;

    // toggle re-init
    @(negedge clk); iso = 1;
    @(negedge clk);
    check("R9 iso rise clears", int'(toggle), 0);
    token(1'b1, "R3 iso data0", 2, 0);
    token(1'b0, "R4 iso zlp", 3, 0);
    strobe(1'b1, 1'b0, "R9 iso tx sets", 1);
    token(1'b1, "R3 iso still data0", 2, 0);
    @(negedge clk); iso = 0;
    token(1'b1, "R9 after reinit data1", 2, 1);

    // stall over everything
    @(negedge clk); stall = 1; rfb = 1;
    token(1'b1, "R2 stall priority", 1, 0);
    @(negedge clk); stall = 0; rfb = 0;
    token(1'b0, "R5 nak", 0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule